// File: doc/BRIEF.md
# Serial Identity CRC-8 Unit

This block keeps a 64-bit device identity made of an 8-bit family code, a 48-bit serial number and an 8-bit check byte. The family code and serial number are written in parallel. The check byte is derived from them and is never written directly. After a start pulse the block walks through 64 bit positions. A bit-valid strobe advances it by one position. Each bit passes through an 8-bit CRC accumulator for the polynomial x^8 + x^5 + x^4 + 1, in reflected form.

The start pulse sets the direction. In transmit direction the block sends its own frame one bit at a time, least significant bit first: the 56 identity bits, then the derived check byte. Every sent bit also goes into the accumulator, so a correct frame ends with the accumulator at zero. In receive direction the accumulator takes the incoming serial bit instead. After the 64th bit a done flag rises, together with a pass flag when the accumulator is zero. A host can therefore validate any identity it reads, or serve its own identity, with the same datapath.

Top module: `romid_crc_unit`

## Requirements
- R1: After reset the identity is family code 0x0B with an all-zero serial number, check_byte holds the CRC of that identity, the direction is receive, and crc_acc, done, crc_ok and bit_out are all 0.
- R2: A load_en cycle stores load_id, with bits [7:0] as the family code and bits [55:8] as the serial number. From the next cycle check_byte equals the CRC of those 56 bits. That CRC starts from zero and takes bit 0 first. For each bit, the feedback is acc[0] XOR bit, the accumulator shifts right by one, and it is XORed with 0x8C when the feedback is 1.
- R3: A start cycle clears crc_acc, the bit position, done and crc_ok by the next cycle, and latches tx_sel as the direction (1 = transmit). A bit_valid in the same cycle as start is discarded.
- R4: In receive direction, each accepted bit_valid cycle folds bit_in into crc_acc by the R2 step, and the new value shows on the next cycle.
- R5: done rises on the cycle after the 64th accepted bit. crc_ok rises with it exactly when crc_acc is then zero.
- R6: While done is high, bit_valid has no effect: crc_acc, done and crc_ok keep their values until the next start.
- R7: In transmit direction, bit_out shows the frame bit at the current position. Positions 0 to 55 carry identity bits 0 to 55. Positions 56 to 63 carry check_byte bits 0 to 7. Each accepted bit_valid folds that bit (bit_in is ignored) and advances the position. A full transmit frame ends with crc_ok at 1.
- R8: When the first 56 bits folded since start are the stored identity, crc_acc equals check_byte at that point.
- R9: A cycle with neither start nor bit_valid leaves crc_acc and the bit position unchanged.
- R10: bit_out is 0 in receive direction and whenever done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Store load_id as the new identity |
| load_id | input | 56 | Family code [7:0] and serial number [55:8] |
| start | input | 1 | Clear the accumulator and position, latch the direction |
| tx_sel | input | 1 | Direction sampled on start: 1 transmit, 0 receive |
| bit_valid | input | 1 | Advance one bit position |
| bit_in | input | 1 | Received serial bit |
| bit_out | output | 1 | Transmitted serial bit at the current position |
| crc_acc | output | 8 | Running CRC accumulator |
| check_byte | output | 8 | CRC derived from the stored identity |
| done | output | 1 | 64 bits have been folded since start |
| crc_ok | output | 1 | Accumulator was zero when done rose |

## Verification
The assertions check on every cycle that the position never passes 64, that done and crc_ok agree with the position and the accumulator, and that idle or post-done cycles leave the state unchanged. They also check that a transmit frame with no reload reaches the check byte at position 56 and ends clean. Only the bench can show that the accumulator values equal the arithmetic CRC, and that the transmitted bit order is right. The bench also covers single-bit errors at every one of the 64 positions, each of which must clear crc_ok, and the discard of a bit that arrives together with start.

// File: rtl/romid_pkg.sv
package romid_pkg;

  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 8'h8C;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // One reflected CRC step: feedback is the low bit XOR the new bit.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] acc,
                                                input logic b);
    logic fb;
    logic [CRC_W-1:0] nxt;
    fb  = acc[0] ^ b;
    nxt = acc >> 1;
    if (fb) nxt = nxt ^ CRC_POLY_REFL;
    return nxt;
  endfunction

endpackage

// File: rtl/romid_store.sv
module romid_store
  import romid_pkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] RESET_FAMILY = 8'h0B,
  localparam int ID_W = FAM_W + SER_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [ID_W-1:0]  load_id,
  output logic [ID_W-1:0]  id_q,
  output logic [CRC_W-1:0] chk_q
);

  localparam logic [ID_W-1:0] RESET_ID = {{SER_W{1'b0}}, RESET_FAMILY};

  function automatic logic [CRC_W-1:0] id_crc(input logic [ID_W-1:0] v);
    logic [CRC_W-1:0] a;
    a = '0;
    for (int i = 0; i < ID_W; i++) a = crc_fold(a, v[i]);
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= RESET_ID;
      chk_q <= id_crc(RESET_ID);
    end else if (load_en) begin
      id_q  <= load_id;
      chk_q <= id_crc(load_id);
    end
  end

  p_load_takes_r2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> id_q == $past(load_id));

  p_store_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(id_q) && $stable(chk_q));

endmodule

// File: rtl/romid_acc.sv
module romid_acc
  import romid_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             bit_i,
  output logic [CRC_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (step)    acc_q <= crc_fold(acc_q, bit_i);
  end

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc_q == '0);

  p_acc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(acc_q));

endmodule

// File: rtl/romid_seq.sv
module romid_seq
  import romid_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tx_sel,
  input  logic             bit_valid,
  output logic [CNT_W-1:0] pos_q,
  output dir_e             dir_q,
  output logic             done_q,
  output logic             step_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] END_POS  = CNT_W'(FRAME_BITS);

  assign step_o = bit_valid && !start && !done_q;
  assign last_o = (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      dir_q  <= DIR_RX;
      done_q <= 1'b0;
    end else if (start) begin
      pos_q  <= '0;
      dir_q  <= tx_sel ? DIR_TX : DIR_RX;
      done_q <= 1'b0;
    end else if (step_o) begin
      pos_q  <= pos_q + 1'b1;
      done_q <= last_o;
    end
  end

  p_pos_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pos_q <= END_POS);

  p_done_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> pos_q == END_POS);

  p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> pos_q == '0 && !done_q);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!start && !bit_valid) |=> $stable(pos_q));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> done_q && $stable(pos_q));

endmodule

// File: rtl/romid_crc_unit.sv
module romid_crc_unit
  import romid_pkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SER_W = 48,
  parameter logic [FAM_W-1:0] RESET_FAMILY = 8'h0B
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic [FAM_W+SER_W-1:0]   load_id,
  input  logic                     start,
  input  logic                     tx_sel,
  input  logic                     bit_valid,
  input  logic                     bit_in,
  output logic                     bit_out,
  output logic [CRC_W-1:0]         crc_acc,
  output logic [CRC_W-1:0]         check_byte,
  output logic                     done,
  output logic                     crc_ok
);

  localparam int ID_W       = FAM_W + SER_W;
  localparam int FRAME_BITS = ID_W + CRC_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic [ID_W-1:0]       id_q;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      pos_q;
  dir_e                  dir_q;
  logic                  step, last, fold_bit;
  logic                  ok_q;

  romid_store #(
    .FAM_W(FAM_W), .SER_W(SER_W), .RESET_FAMILY(RESET_FAMILY)
  ) u_store (
    .clk(clk), .rst(rst), .load_en(load_en), .load_id(load_id),
    .id_q(id_q), .chk_q(check_byte)
  );

  romid_seq #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .tx_sel(tx_sel),
    .bit_valid(bit_valid), .pos_q(pos_q), .dir_q(dir_q),
    .done_q(done), .step_o(step), .last_o(last)
  );

  // Transmit frame: identity first, derived check byte in the top byte.
  assign frame    = {check_byte, id_q};
  assign bit_out  = (dir_q == DIR_TX) && !done && frame[pos_q[IDX_W-1:0]];
  assign fold_bit = (dir_q == DIR_TX) ? bit_out : bit_in;

  romid_acc u_acc (
    .clk(clk), .rst(rst), .clear(start), .step(step),
    .bit_i(fold_bit), .acc_q(crc_acc)
  );

  always_ff @(posedge clk) begin
    if (rst || start)    ok_q <= 1'b0;
    else if (step && last) ok_q <= (crc_fold(crc_acc, fold_bit) == '0);
  end
  assign crc_ok = ok_q;

  // Checker state: identity changed since the last start.
  logic reloaded_q;
  always_ff @(posedge clk) begin
    if (rst || start) reloaded_q <= 1'b0;
    else if (load_en) reloaded_q <= 1'b1;
  end

  p_ok_means_zero_r5: assert property (@(posedge clk) disable iff (rst)
    crc_ok |-> done && crc_acc == '0);

  p_ok_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(crc_ok) && $stable(crc_acc));

  p_midpoint_match_r8: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_TX && pos_q == CNT_W'(ID_W) && !reloaded_q) |-> crc_acc == check_byte);

  p_tx_clean_end_r7: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_TX && done && !reloaded_q) |-> crc_ok);

  p_rx_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_RX || done) |-> !bit_out);

endmodule

// File: tb/tb_romid_crc_unit.sv
module tb_romid_crc_unit;

  logic        clk = 1'b0;
  logic        rst, load_en, start, tx_sel, bit_valid, bit_in;
  logic [55:0] load_id;
  logic        bit_out, done, crc_ok;
  logic [7:0]  crc_acc, check_byte;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  romid_crc_unit dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_id(load_id),
    .start(start), .tx_sel(tx_sel), .bit_valid(bit_valid), .bit_in(bit_in),
    .bit_out(bit_out), .crc_acc(crc_acc), .check_byte(check_byte),
    .done(done), .crc_ok(crc_ok)
  );

  function automatic logic [7:0] step_crc(input logic [7:0] a, input logic b);
    logic [7:0] n;
    n = {1'b0, a[7:1]};
    if (a[0] ^ b) n = n ^ 8'h8C;
    return n;
  endfunction

  function automatic logic [7:0] model_crc(input logic [55:0] v);
    logic [7:0] a = 8'h00;
    for (int i = 0; i < 56; i++) a = step_crc(a, v[i]);
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(input logic tx);
    start = 1'b1; tx_sel = tx;
    @(negedge clk);
    start = 1'b0; tx_sel = 1'b0;
  endtask

  task automatic do_load(input logic [55:0] v);
    load_en = 1'b1; load_id = v;
    @(negedge clk);
    load_en = 1'b0;
    check(check_byte == model_crc(v), "R2", "check_byte", check_byte, model_crc(v));
  endtask

  task automatic pulse_bit(input logic b);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  // Transmit the stored identity and compare every bit and accumulator value.
  task automatic tx_frame(input logic [55:0] v);
    logic [63:0] fr;
    logic [7:0]  a = 8'h00;
    fr = {model_crc(v), v};
    do_start(1'b1);
    check(crc_acc == 8'h00 && !done && !crc_ok, "R3", "start clear", crc_acc, 0);
    for (int i = 0; i < 64; i++) begin
      check(bit_out == fr[i], "R7", "tx bit", bit_out, fr[i]);
      pulse_bit(~fr[i]);
      a = step_crc(a, fr[i]);
      check(crc_acc == a, "R7", "tx acc", crc_acc, a);
      if (i == 55) check(crc_acc == model_crc(v), "R8", "midpoint", crc_acc, model_crc(v));
    end
    check(done && crc_ok, "R7", "tx end ok", {done, crc_ok}, 2'b11);
    check(!bit_out, "R10", "bit_out after done", bit_out, 0);
  endtask

  // Receive a frame, optionally with one bit flipped (flip < 0 for none).
  task automatic rx_frame(input logic [55:0] v, input int flip);
    logic [63:0] fr;
    logic [7:0]  a = 8'h00;
    logic        b;
    fr = {model_crc(v), v};
    do_start(1'b0);
    for (int i = 0; i < 64; i++) begin
      b = fr[i] ^ (i == flip);
      check(!done, "R5", "done early", done, 0);
      check(!bit_out, "R10", "rx bit_out", bit_out, 0);
      pulse_bit(b);
      a = step_crc(a, b);
      check(crc_acc == a, "R4", "rx acc", crc_acc, a);
    end
    check(done, "R5", "done", done, 1);
    check(crc_ok == (flip < 0), "R5", "crc_ok", crc_ok, flip < 0);
  endtask

  logic [55:0] seed;
  logic [7:0]  hold;

  initial begin
    rst = 1'b1; load_en = 0; load_id = '0; start = 0; tx_sel = 0;
    bit_valid = 0; bit_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(crc_acc == 0 && !done && !crc_ok && !bit_out, "R1", "reset outputs",
          {crc_acc, done, crc_ok, bit_out}, 0);
    check(check_byte == model_crc({48'h0, 8'h0B}), "R1", "reset check_byte",
          check_byte, model_crc({48'h0, 8'h0B}));
    tx_frame({48'h0, 8'h0B});
    check(dut.bit_out == 1'b0, "R10", "post-frame", bit_out, 0);

    // R6: bits after done are ignored
    hold = crc_acc;
    pulse_bit(1'b1);
    pulse_bit(1'b0);
    check(crc_acc == hold && done && crc_ok, "R6", "ignored after done",
          {crc_acc, done, crc_ok}, {hold, 2'b11});

    // Sweep of identities in both directions
    seed = 56'h00_00FB_C52B_0B;
    for (int k = 0; k < 10; k++) begin
      logic [55:0] v;
      case (k)
        0: v = '0;
        1: v = '1;
        2: v = 56'h1;
        3: v = 56'h80_0000_0000_0000;
        default: begin
          seed = seed * 56'h5851F42D4C957F + 56'h14057B7EF767;
          v = seed;
        end
      endcase
      do_load(v);
      tx_frame(v);
      rx_frame(v, -1);
    end

    // Single-bit errors at every position
    for (int f = 0; f < 64; f++) rx_frame(56'hA5_5AC3_3C0F_F00B, f);

    // R9: idle cycles hold, R3: start beats a simultaneous bit
    do_start(1'b0);
    pulse_bit(1'b1);
    pulse_bit(1'b1);
    hold = crc_acc;
    repeat (4) @(negedge clk);
    check(crc_acc == hold, "R9", "idle hold", crc_acc, hold);
    start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_valid = 1'b0;
    check(crc_acc == 0, "R3", "start wins", crc_acc, 0);
    for (int i = 0; i < 63; i++) pulse_bit(1'b0);
    check(!done, "R3", "no bit taken with start", done, 0);
    pulse_bit(1'b0);
    check(done && crc_ok, "R5", "all-zero frame", {done, crc_ok}, 2'b11);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule